// File: doc/BRIEF.md
# Asynchronous Static RAM Byte Controller

This controller sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host asks for one byte transfer at a time over a request/ready handshake that carries an address, a write flag and write data. The controller then runs the RAM's control pins through a fixed sequence of phases and returns read data with a one-cycle completion pulse. Each phase length is a whole number of clock cycles. These counts are computed from the RAM's nanosecond limits and a clock-period parameter.

The state machine has seven states. IDLE offers `host_ready` and keeps the RAM deselected. A read runs RD_ACCESS and then RD_TURN. In RD_ACCESS both chip selects are asserted and the output enable is low. RD_TURN deselects the RAM so that its drivers release the bus. A write runs WR_SETUP, WR_STROBE, WR_DRIVE and WR_HOLD. WR_SETUP selects the RAM with the strobe high. WR_STROBE lowers the write strobe. WR_DRIVE keeps the strobe low and drives the bus. WR_HOLD raises the strobe while the bus is still driven.

The transitions are:
- IDLE→RD_ACCESS or IDLE→WR_SETUP on an accepted request.
- RD_ACCESS→RD_TURN when the access count expires.
- RD_TURN→IDLE when the release count expires.
- WR_SETUP→WR_STROBE after one cycle.
- WR_STROBE→WR_DRIVE after one cycle.
- WR_DRIVE→WR_HOLD when the strobe count expires.
- WR_HOLD→IDLE after one cycle.

Top module: `sramc_async_ctrl`

## Requirements
- R1: While reset is held, and in IDLE afterwards, `host_ready`=1, `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `host_done`=0 at every clock edge where no operation is running.
- R2: A request is taken only on a clock edge where `host_req` and `host_ready` are both 1. `host_ready` stays 0 from that edge until the operation completes, and a request raised while busy has no effect.
- R3: A read keeps both selects asserted (`mem_cs_n`=0, `mem_cs`=1), `mem_oe_n`=0 and `mem_we_n`=1 for exactly N_RD consecutive cycles, with `mem_addr` constant. N_RD is the largest of the cycle counts for access time, output-enable time and cycle time.
- R4: `host_rdata` takes `mem_dq_i` at the clock edge that ends the read access window. It holds that value through completion and until the next read.
- R5: A write holds both selects asserted with `mem_oe_n`=1 throughout. It gives one cycle with `mem_we_n`=1, then N_WP cycles with `mem_we_n`=0, then one cycle with `mem_we_n`=1. `mem_addr` does not change while the strobe is low or on the cycle it rises.
- R6: `mem_dq_oe` is 1 from the cycle after `mem_we_n` falls through the cycle after it rises, N_WP cycles in all. `mem_dq_o` carries the accepted write byte whenever it is driven.
- R7: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0.
- R8: `host_done` is a single-cycle pulse in the first IDLE cycle after an operation. It comes N_RD+N_HIZ edges after acceptance for a read and N_WP+2 edges after acceptance for a write.
- R9: After the read window, the RAM is deselected with `mem_oe_n`=1 for N_HIZ cycles before the controller offers `host_ready` again.
- R10: Every phase count is ceil(ns / CLK_PERIOD_NS), with a minimum of 1. The strobe count N_WP is also at least the data-setup count plus 1, and at least the cycle-time count minus 2. At a 20 ns period, N_RD=3, N_WP=3 and N_HIZ=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request |
| host_ready | output | 1 | Controller can accept a request (IDLE) |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Byte to write |
| host_rdata | output | 8 | Last byte read |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | RAM address |
| mem_cs_n | output | 1 | Active-low RAM select |
| mem_cs | output | 1 | Active-high RAM select |
| mem_oe_n | output | 1 | Active-low RAM output enable |
| mem_we_n | output | 1 | Active-low RAM write strobe |
| mem_dq_o | output | 8 | Data toward the RAM |
| mem_dq_i | input | 8 | Data from the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench instance uses CLK_PERIOD_NS = 20 and keeps every nanosecond limit at its default. This gives N_RD=3, N_WP=3 and N_HIZ=1, which are short enough to count every phase of every operation cycle by cycle. With these values the strobe count comes from the pulse width and the data-setup rule at the same time, so both bounds are exercised together. A bus-level RAM model supplies stale data until the address has been stable for three cycles. A capture one edge early, or a strobe one cycle short, therefore shows up as wrong data or a wrong count.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_DRIVE,
        ST_WR_HOLD
    } sramc_state_e;

    // Whole cycles covering a nanosecond window, never fewer than one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/sramc_capture.sv
module sramc_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/sramc_async_ctrl.sv
module sramc_async_ctrl
    import sramc_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned T_ACC_NS      = 55,
    parameter int unsigned T_OE_NS       = 20,
    parameter int unsigned T_CYC_NS      = 55,
    parameter int unsigned T_WP_NS       = 45,
    parameter int unsigned T_DS_NS       = 25,
    parameter int unsigned T_HIZ_NS      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    output logic              host_ready,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe
);
    localparam int unsigned C_ACC  = ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS);
    localparam int unsigned C_OE   = ns_to_cycles(T_OE_NS,  CLK_PERIOD_NS);
    localparam int unsigned C_CYC  = ns_to_cycles(T_CYC_NS, CLK_PERIOD_NS);
    localparam int unsigned C_WP   = ns_to_cycles(T_WP_NS,  CLK_PERIOD_NS);
    localparam int unsigned C_DS   = ns_to_cycles(T_DS_NS,  CLK_PERIOD_NS);
    localparam int unsigned N_HIZ  = ns_to_cycles(T_HIZ_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RD   = max3(C_ACC, C_OE, C_CYC);
    // Strobe: long enough for pulse width, for data setup after the drive
    // starts one cycle late, and for the whole write to span a cycle time.
    localparam int unsigned N_WP   = max3(C_WP, C_DS + 1, (C_CYC > 2) ? C_CYC - 2 : 2);
    localparam int unsigned N_MAX  = max3(N_RD, N_WP, N_HIZ);
    localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_HIZ = CNT_W'(N_HIZ - 1);
    localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(N_WP - 2);

    sramc_state_e state, state_nx;
    logic             phase_last;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             accept;
    logic             rd_capture;
    logic             done_q;

    assign accept     = (state == ST_IDLE) && host_req;
    assign rd_capture = (state == ST_RD_ACCESS) && phase_last;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= (state != ST_IDLE) && (state_nx == ST_IDLE);
        end
    end

    // Next state and phase-timer loading
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (host_req) state_nx = host_wr ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS: if (phase_last) state_nx = ST_RD_TURN;
            ST_RD_TURN:   if (phase_last) state_nx = ST_IDLE;
            ST_WR_SETUP:  state_nx = ST_WR_STROBE;
            ST_WR_STROBE: state_nx = ST_WR_DRIVE;
            ST_WR_DRIVE:  if (phase_last) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
        tmr_load = (state_nx != state);
        unique case (state_nx)
            ST_RD_ACCESS: tmr_val = LD_RD;
            ST_RD_TURN:   tmr_val = LD_HIZ;
            ST_WR_DRIVE:  tmr_val = LD_WP;
            default:      tmr_val = '0;
        endcase
    end

    // Pin outputs per state
    always_comb begin
        host_ready = 1'b0;
        mem_cs_n   = 1'b1;
        mem_cs     = 1'b0;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        unique case (state)
            ST_IDLE:      host_ready = 1'b1;
            ST_RD_ACCESS: begin
                mem_cs_n = 1'b0; mem_cs = 1'b1; mem_oe_n = 1'b0;
            end
            ST_RD_TURN:   ;
            ST_WR_SETUP:  begin
                mem_cs_n = 1'b0; mem_cs = 1'b1;
            end
            ST_WR_STROBE: begin
                mem_cs_n = 1'b0; mem_cs = 1'b1; mem_we_n = 1'b0;
            end
            ST_WR_DRIVE:  begin
                mem_cs_n = 1'b0; mem_cs = 1'b1; mem_we_n = 1'b0; mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD:   begin
                mem_cs_n = 1'b0; mem_cs = 1'b1; mem_dq_oe = 1'b1;
            end
            default:      ;
        endcase
    end

    assign host_done = done_q;

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (phase_last)
    );

    sramc_capture #(.W(ADDR_W)) u_addr_q (
        .clk (clk), .rst_n (rst_n), .en (accept), .d (host_addr), .q (mem_addr)
    );

    sramc_capture #(.W(DATA_W)) u_wdata_q (
        .clk (clk), .rst_n (rst_n), .en (accept), .d (host_wdata), .q (mem_dq_o)
    );

    sramc_capture #(.W(DATA_W)) u_rdata_q (
        .clk (clk), .rst_n (rst_n), .en (rd_capture), .d (mem_dq_i), .q (host_rdata)
    );

    // Guards
    assert_no_bus_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_strobe_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n));

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> $stable(mem_addr));

    assert_read_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs && !mem_dq_oe));

    assert_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_release_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_cs_n && !host_ready));

endmodule

// File: tb/sim_sramc_async_ctrl.sv
`timescale 1ns/1ps
module sim_sramc_async_ctrl;
    // Hand-derived counts for CLK_PERIOD_NS = 20 (R10)
    localparam int N_RD  = 3;
    localparam int N_WP  = 3;
    localparam int N_HIZ = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_ready;
    logic        host_wr = 1'b0;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_done;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = 8'hEE;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sramc_async_ctrl #(.CLK_PERIOD_NS(20)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_done(host_done), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- RAM model and bus monitor ----------------
    logic [7:0] ram [int];
    int         we_low = 0;
    int         rd_cnt = 0;
    bit         prev_rd = 0;
    bit         prev_we_low = 0;
    logic [16:0] prev_addr = '0;

    function automatic logic [7:0] ram_get(input logic [16:0] a);
        if (ram.exists(int'(a))) return ram[int'(a)];
        return 8'h5A;
    endfunction

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_cs_n && mem_cs) begin
            if (!mem_dq_oe) chk(1'b0, "R6", "bus undriven at strobe rise", 0, 1);
            ram[int'(mem_addr)] = mem_dq_o;
        end
    end

    always @(negedge clk) begin
        bit rd_now;
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R7", "bus fight", 1, 0);
            if (!mem_we_n && prev_we_low && mem_addr != prev_addr)
                chk(1'b0, "R5", "address moved under strobe", int'(mem_addr), int'(prev_addr));
            if (!mem_we_n) we_low++;
            else begin
                if (we_low != 0) chk(we_low >= N_WP, "R5", "strobe width", we_low, N_WP);
                we_low = 0;
            end
            rd_now = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n;
            if (rd_now && prev_rd && mem_addr == prev_addr) rd_cnt++;
            else rd_cnt = rd_now ? 1 : 0;
            mem_dq_i = (rd_now && rd_cnt >= 3) ? ram_get(mem_addr) : 8'hEE;
            prev_rd = rd_now;
            prev_we_low = !mem_we_n;
            prev_addr = mem_addr;
        end
    end

    // ---------------- operation driver ----------------
    int  o_edges, o_rd, o_we, o_drv, o_desel, o_setup;
    bit  o_data_ok, o_ready_bad;

    task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_req = 1'b0;
        o_edges = 0; o_rd = 0; o_we = 0; o_drv = 0; o_desel = 0; o_setup = 0;
        o_data_ok = 1; o_ready_bad = 0;
        forever begin
            if (host_ready) o_ready_bad = 1;
            if (!mem_cs_n && mem_cs && !mem_oe_n) o_rd++;
            if (!mem_we_n) o_we++;
            if (mem_dq_oe) begin
                o_drv++;
                if (mem_dq_o != d) o_data_ok = 0;
            end
            if (mem_cs_n && !mem_cs && mem_oe_n) o_desel++;
            if (!mem_cs_n && mem_cs && mem_we_n && mem_oe_n) o_setup++;
            @(posedge clk); #1;
            o_edges++;
            if (host_done || o_edges > 40) break;
        end
    endtask

    // {write, address, data (write byte or expected read byte)}
    localparam logic [25:0] VEC [10] = '{
        {1'b1, 17'h00000, 8'h3C},
        {1'b1, 17'h1FFFF, 8'hC3},
        {1'b1, 17'h0AAAA, 8'h55},
        {1'b1, 17'h15555, 8'hAA},
        {1'b0, 17'h00000, 8'h3C},
        {1'b0, 17'h1FFFF, 8'hC3},
        {1'b0, 17'h15555, 8'hAA},
        {1'b1, 17'h00000, 8'hF0},
        {1'b0, 17'h00000, 8'hF0},
        {1'b0, 17'h0AAAA, 8'h55}
    };

    logic [7:0]  last_rd;
    logic [16:0] v_addr;
    logic [7:0]  v_data;
    bit          v_wr;
    int          guard;

    initial begin
        // Reset state (R1)
        repeat (3) @(posedge clk);
        #1;
        chk(host_ready == 1'b1, "R1", "ready in reset", host_ready, 1);
        chk(mem_cs_n == 1'b1 && mem_cs == 1'b0, "R1", "deselected in reset",
            {mem_cs_n, mem_cs}, 2'b10);
        chk(mem_oe_n && mem_we_n && !mem_dq_oe && !host_done, "R1", "quiet pins in reset",
            {mem_oe_n, mem_we_n, mem_dq_oe, host_done}, 4'b1100);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        chk(host_ready && mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1", "idle pins after reset", {host_ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe},
            6'b110110);
        last_rd = host_rdata;

        // Vector table
        for (int i = 0; i < 10; i++) begin
            v_wr = VEC[i][25]; v_addr = VEC[i][24:8]; v_data = VEC[i][7:0];
            run_op(v_wr, v_addr, v_data);
            chk(!o_ready_bad, "R2", "ready low while busy", o_ready_bad, 0);
            if (v_wr) begin
                chk(o_edges == N_WP + 2, "R8", "write completion edges", o_edges, N_WP + 2);
                chk(o_we == N_WP, "R10", "write strobe cycles", o_we, N_WP);
                chk(o_setup == 2, "R5", "select with strobe high (setup+hold)", o_setup, 2);
                chk(o_drv == N_WP && o_data_ok, "R6", "drive cycles / data", o_drv, N_WP);
                chk(o_rd == 0, "R5", "output enable during write", o_rd, 0);
                chk(host_rdata == last_rd, "R4", "read data held across write", host_rdata, last_rd);
                chk(ram_get(v_addr) == v_data, "R5", "byte stored", ram_get(v_addr), v_data);
            end else begin
                chk(o_edges == N_RD + N_HIZ, "R8", "read completion edges", o_edges, N_RD + N_HIZ);
                chk(o_rd == N_RD, "R3", "read window cycles", o_rd, N_RD);
                chk(o_desel == N_HIZ, "R9", "release cycles", o_desel, N_HIZ);
                chk(o_we == 0 && o_drv == 0, "R3", "no strobe or drive in read", o_we + o_drv, 0);
                chk(host_rdata == v_data, "R4", "read data", host_rdata, v_data);
                last_rd = host_rdata;
            end
            @(posedge clk); #1;
            chk(!host_done, "R8", "done lasts one cycle", host_done, 0);
        end

        // Request while busy is ignored (R2)
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 17'h0AAAA;
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = 17'h00000; host_wdata = 8'hFF;
        @(posedge clk); #1;
        chk(!host_ready, "R2", "ready low during read", host_ready, 0);
        @(negedge clk); host_req = 1'b0;
        guard = 0;
        while (!host_done && guard < 40) begin @(posedge clk); #1; guard++; end
        chk(host_rdata == 8'h55, "R4", "read during busy request", host_rdata, 8'h55);
        @(posedge clk); #1;
        chk(host_ready && mem_cs_n, "R2", "idle after ignored request", host_ready, 1);
        run_op(1'b0, 17'h00000, 8'hF0);
        chk(host_rdata == 8'hF0, "R2", "busy write request had no effect", host_rdata, 8'hF0);

        // Back-to-back writes to distinct addresses then read both
        run_op(1'b1, 17'h00001, 8'h81);
        run_op(1'b1, 17'h00002, 8'h7E);
        run_op(1'b0, 17'h00001, 8'h81);
        chk(host_rdata == 8'h81, "R5", "first of back-to-back writes", host_rdata, 8'h81);
        run_op(1'b0, 17'h00002, 8'h7E);
        chk(host_rdata == 8'h7E, "R5", "second of back-to-back writes", host_rdata, 8'h7E);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule